// File: doc/BRIEF.md
# Buffered SPI Host Engine

This block is a byte-oriented SPI master that works from two on-chip byte buffers. Software fills the command buffer over a simple register bus, then writes one control word that carries the byte count, a clock divider code, the clock mode, a chip-select index, a keep-select flag and a start bit. The engine shifts each command byte out most significant bit first. In the same bit times it captures the incoming serial data, and it stores each received byte at the same index in the response buffer.

When the last byte has been sent, the engine sets a sticky completion flag. Software clears that flag by writing a one to it. A mask bit decides whether the flag reaches the interrupt output. Transfers longer than one buffer are split into chunks by software. The keep-select flag holds the chosen chip select low across those chunks.

Top module: `spi_buf_host`

## Requirements
- R1: The command buffer holds BUF_BYTES bytes at byte addresses 0x000 upward. A byte written there on wdata[7:0] reads back on rdata[7:0]. The response buffer starts at 0x200 and cannot be written from the bus.
- R2: The control word at 0x400 reads back as written, with two exceptions: bit 0 reads as the busy state, and the start bit therefore reads 0 once the transfer ends. The fields are: select [27:25], length [16:8], divider code [7:5], keep-select [4], mode [2] and start [0].
- R3: Each command byte leaves on spi_mosi MSB first and is stable at every rising SCK edge. The MISO bit sampled at each rising edge of command byte n goes into response byte n, also MSB first.
- R4: Mode bit 0 gives an SCK idle level of 0. Mode bit 1 gives an SCK idle level of 1. Data is sampled on the rising edge in both modes.
- R5: For divider code c, the effective divider is d = c for c of 2 to 7 and d = 2 for c of 0 or 1. The SCK period is d system clocks and the high phase is floor(d/2) clocks.
- R6: A select value i from 0 to 6 drives spi_cs_n[i] low while the transfer runs. A select value of 7 drives no line low. At most one line is ever low.
- R7: While keep-select is 1, the chosen line stays low between frames. It goes high once a control write clears keep-select.
- R8: The end of a transfer sets bit 8 of the event word at 0x420. Writing a 1 to that bit clears it. A start with length 0 sets the flag at once and produces no SCK edges.
- R9: irq is high when the event flag is set and bit 8 of the mask word at 0x424 is 0. The mask word resets to 0x100.
- R10: Any control write made while busy is ignored: no field changes and no second transfer starts.
- R11: A length above BUF_BYTES transfers exactly BUF_BYTES bytes.
- R12: After reset all chip selects are high, SCK is low, irq is low, and the control and event words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register/buffer write strobe |
| bus_re | input | 1 | Read strobe; data returns one clock later |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 7 | Active-low chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with BUF_BYTES = 8. With that setting, a completely full buffer and a length larger than the buffer take only a few dozen SCK cycles each, so the clamp in R11 and the last-index write into the response buffer are both covered. The divider, mode and select fields keep their full ranges. A serial device model in the bench measures the SCK period and high time for several codes, including a code below the valid range, so the effect of the divider can be seen directly at the pins.

// File: rtl/spibh_pkg.sv
`timescale 1ns/1ps
package spibh_pkg;

  localparam int unsigned LEN_W  = 9;
  localparam int unsigned NSEL   = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD
  } eng_state_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Divider codes below 2 fall back to the fastest legal divider.
  function automatic logic [2:0] eff_div(input logic [2:0] code);
    return (code < 3'd2) ? 3'd2 : code;
  endfunction

  function automatic logic [2:0] hi_len(input logic [2:0] d);
    return d >> 1;
  endfunction

  function automatic logic [2:0] lo_len(input logic [2:0] d);
    return d - (d >> 1);
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l,
                                                 input int unsigned cap);
    return (32'(l) > cap) ? LEN_W'(cap) : l;
  endfunction

endpackage

// File: rtl/spibh_bytebuf.sv
`timescale 1ns/1ps
module spibh_bytebuf #(
  parameter int unsigned DEPTH = 320,
  parameter int unsigned NRD   = 1,
  localparam int unsigned IDX_W = spibh_pkg::idx_w(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [7:0]                wdata,
  input  logic [NRD-1:0][IDX_W-1:0] ridx,
  output logic [NRD-1:0][7:0]       rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(widx) < DEPTH)) mem[widx] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (32'(ridx[g]) < DEPTH) ? mem[ridx[g]] : 8'h00;
  end

endmodule

// File: rtl/spibh_engine.sv
`timescale 1ns/1ps
module spibh_engine #(
  parameter int unsigned BUF_BYTES = 320,
  localparam int unsigned IDX_W = spibh_pkg::idx_w(BUF_BYTES),
  localparam int unsigned LEN_W = spibh_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [2:0]       div,
  input  logic             cpol,
  input  logic [7:0]       cmd_byte,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             rsp_we,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [7:0]       rsp_byte,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             done
);
  import spibh_pkg::*;

  eng_state_e       state;
  logic [2:0]       cnt, div_q, bit_i;
  logic [LEN_W-1:0] len_q, byte_idx;
  logic [7:0]       tx_sh, rx_sh;
  logic             ph_end, last_bit, last_byte;

  assign ph_end    = (cnt == 3'd0);
  assign last_bit  = (bit_i == 3'd7);
  assign last_byte = (byte_idx == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; div_q <= 3'd2; bit_i <= '0;
      len_q <= '0; byte_idx <= '0; tx_sh <= '0; rx_sh <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_SETUP; len_q <= len; div_q <= div;
          cnt <= lo_len(div) - 3'd1; byte_idx <= '0; bit_i <= '0;
          tx_sh <= cmd_byte;
        end
        ST_SETUP: if (ph_end) begin
          state <= ST_LOW; cnt <= lo_len(div_q) - 3'd1;
        end else cnt <= cnt - 3'd1;
        ST_LOW: if (ph_end) begin
          state <= ST_HIGH; cnt <= hi_len(div_q) - 3'd1;
          rx_sh <= {rx_sh[6:0], miso};
        end else cnt <= cnt - 3'd1;
        ST_HIGH: if (ph_end) begin
          cnt <= lo_len(div_q) - 3'd1;
          if (last_bit && last_byte) begin
            state <= ST_HOLD;
          end else if (last_bit) begin
            state <= ST_LOW; byte_idx <= byte_idx + LEN_W'(1);
            bit_i <= '0; tx_sh <= cmd_byte;
          end else begin
            state <= ST_LOW; bit_i <= bit_i + 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end else cnt <= cnt - 3'd1;
        ST_HOLD: if (ph_end) state <= ST_IDLE;
                 else cnt <= cnt - 3'd1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_idx  = (state == ST_IDLE) ? '0 : IDX_W'(byte_idx + LEN_W'(1));
  assign rsp_we   = (state == ST_LOW) && ph_end && last_bit;
  assign rsp_idx  = IDX_W'(byte_idx);
  assign rsp_byte = {rx_sh[6:0], miso};
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_HOLD) && ph_end;
  assign mosi     = busy ? tx_sh[7] : 1'b0;
  assign sck      = (state == ST_HIGH) ? 1'b1 :
                    (state == ST_LOW)  ? 1'b0 : cpol;

  // R5
  hi_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH) |-> (cnt < hi_len(div_q)));

  // R11
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_idx < len_q));

  // R3
  rx_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |=> (state == ST_HIGH));

endmodule

// File: rtl/spi_buf_host.sv
`timescale 1ns/1ps
module spi_buf_host #(
  parameter int unsigned BUF_BYTES = 320,
  localparam int unsigned IDX_W = spibh_pkg::idx_w(BUF_BYTES),
  localparam int unsigned NSEL  = spibh_pkg::NSEL,
  localparam int unsigned LEN_W = spibh_pkg::LEN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [10:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            spi_sck,
  output logic            spi_mosi,
  input  logic            spi_miso,
  output logic [NSEL-1:0] spi_cs_n,
  output logic            irq
);
  import spibh_pkg::*;

  logic [31:0] ctl_q, mask_q, rdata_q;
  logic        evt_q, busy, eng_done, zero_done, done_any;
  logic        ctl_wr, evt_wr, mask_wr, go_start, cs_active, in_range;
  logic        cmd_sel, rsp_sel, rsp_we;
  logic [LEN_W-1:0]          len_eff;
  logic [IDX_W-1:0]          eng_idx, rsp_idx;
  logic [7:0]                rsp_byte;
  logic [1:0][IDX_W-1:0]     cmd_ridx;
  logic [1:0][7:0]           cmd_rdata;
  logic [0:0][IDX_W-1:0]     rsp_ridx;
  logic [0:0][7:0]           rsp_rdata;

  assign in_range = 32'(bus_addr[8:0]) < BUF_BYTES;
  assign cmd_sel  = (bus_addr[10:9] == 2'b00) && in_range;
  assign rsp_sel  = (bus_addr[10:9] == 2'b01) && in_range;
  assign ctl_wr   = bus_we && (bus_addr == 11'h400);
  assign evt_wr   = bus_we && (bus_addr == 11'h420);
  assign mask_wr  = bus_we && (bus_addr == 11'h424);
  assign go_start = ctl_wr && !busy && bus_wdata[0];
  assign len_eff  = clamp_len(bus_wdata[16:8], BUF_BYTES);
  assign zero_done = go_start && (len_eff == '0);
  assign done_any = eng_done || zero_done;

  assign cmd_ridx[0] = IDX_W'(bus_addr[8:0]);
  assign cmd_ridx[1] = eng_idx;
  assign rsp_ridx[0] = IDX_W'(bus_addr[8:0]);

  spibh_bytebuf #(.DEPTH(BUF_BYTES), .NRD(2)) u_cmd_buf (
    .clk(clk), .we(bus_we && cmd_sel), .widx(IDX_W'(bus_addr[8:0])),
    .wdata(bus_wdata[7:0]), .ridx(cmd_ridx), .rdata(cmd_rdata));

  spibh_bytebuf #(.DEPTH(BUF_BYTES), .NRD(1)) u_rsp_buf (
    .clk(clk), .we(rsp_we), .widx(rsp_idx), .wdata(rsp_byte),
    .ridx(rsp_ridx), .rdata(rsp_rdata));

  spibh_engine #(.BUF_BYTES(BUF_BYTES)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(go_start && (len_eff != '0)),
    .len(len_eff), .div(eff_div(bus_wdata[7:5])), .cpol(ctl_q[2]),
    .cmd_byte(cmd_rdata[1]), .cmd_idx(eng_idx), .rsp_we(rsp_we),
    .rsp_idx(rsp_idx), .rsp_byte(rsp_byte), .sck(spi_sck),
    .mosi(spi_mosi), .miso(spi_miso), .busy(busy), .done(eng_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; mask_q <= 32'h100; evt_q <= 1'b0; rdata_q <= '0;
    end else begin
      if (ctl_wr && !busy) ctl_q <= bus_wdata;
      if (mask_wr) mask_q <= bus_wdata;
      if (done_any) evt_q <= 1'b1;
      else if (evt_wr && bus_wdata[8]) evt_q <= 1'b0;
      if (bus_re) begin
        if (cmd_sel) rdata_q <= {24'h0, cmd_rdata[0]};
        else if (rsp_sel) rdata_q <= {24'h0, rsp_rdata[0]};
        else if (bus_addr == 11'h400) rdata_q <= {ctl_q[31:1], busy};
        else if (bus_addr == 11'h420) rdata_q <= {23'h0, evt_q, 8'h0};
        else if (bus_addr == 11'h424) rdata_q <= mask_q;
        else rdata_q <= '0;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = evt_q && !mask_q[8];
  assign cs_active = busy || ctl_q[4];

  for (genvar g = 0; g < NSEL; g++) begin : g_cs
    assign spi_cs_n[g] = !(cs_active && (ctl_q[27:25] == 3'(g)));
  end

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R8
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_any |=> evt_q);

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && busy) |=> $stable(ctl_q));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done_any) || $past(mask_wr)));

endmodule

// File: tb/spi_buf_host_bench.sv
`timescale 1ns/1ps
module spi_buf_host_bench;
  localparam int BUF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0, spi_miso = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sck, spi_mosi, irq;
  logic [6:0] spi_cs_n, cs_mid;

  int n_chk = 0, n_fail = 0;
  logic [7:0] sl_rsp [16];
  logic [7:0] sl_got [16];
  logic [7:0] cmd_ref [16];
  int rcnt = 0;
  longint t_rise = 0, per = 0, hi_t = 0;

  always #2 clk = ~clk;

  spi_buf_host #(.BUF_BYTES(BUF)) u_spi_buf_host (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .irq(irq));

  // serial device model
  always @(posedge spi_sck) if (spi_cs_n != 7'h7f && rcnt < 120) begin
    sl_got[rcnt/8][7-(rcnt%8)] = spi_mosi;
    rcnt = rcnt + 1;
    per = $time - t_rise;
    t_rise = $time;
  end
  always @(negedge spi_sck) if (spi_cs_n != 7'h7f && rcnt < 120) begin
    hi_t = $time - t_rise;
    spi_miso = sl_rsp[rcnt/8][7-(rcnt%8)];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl_val(input int sel, input int len,
      input int code, input bit frc, input bit m3);
    return (32'(sel) << 25) | (32'(len) << 8) | (32'(code) << 5) |
           (32'(frc) << 4) | (32'(m3) << 2);
  endfunction

  task automatic load_cmd(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      cmd_ref[i] = 8'(seed * 37 + i * 29 + 5);
      sl_rsp[i]  = 8'(seed * 91 + i * 53 + 17);
      bus_wr(11'(i), {24'h0, cmd_ref[i]});
    end
  endtask

  task automatic wait_evt();
    logic [31:0] d;
    for (int k = 0; k < 4000; k++) begin
      bus_rd(11'h420, d);
      if (d[8]) break;
    end
  endtask

  task automatic run_frame(input int len, input int code, input bit m3,
                           input int sel, input bit frc);
    logic [31:0] cv;
    cv = ctl_val(sel, len, code, frc, m3);
    bus_wr(11'h400, cv);
    rcnt = 0; spi_miso = sl_rsp[0][7];
    bus_wr(11'h400, cv | 32'h1);
    repeat (3) @(negedge clk);
    cs_mid = spi_cs_n;
    wait_evt();
  endtask

  task automatic check_xfer(input int n, input string tag);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      chk(sl_got[i] == cmd_ref[i], {tag, " R3 mosi byte"}, 32'(sl_got[i]), 32'(cmd_ref[i]));
      bus_rd(11'h200 + 11'(i), d);
      chk(d[7:0] == sl_rsp[i], {tag, " R3 response byte"}, d, 32'(sl_rsp[i]));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(spi_cs_n == 7'h7f, "R12 cs_n", 32'(spi_cs_n), 32'h7f);
    chk(spi_sck == 1'b0, "R12 sck", 32'(spi_sck), 0);
    chk(irq == 1'b0, "R12 irq", 32'(irq), 0);
    bus_rd(11'h400, d); chk(d == 0, "R12 ctl", d, 0);
    bus_rd(11'h420, d); chk(d == 0, "R12 evt", d, 0);
    bus_rd(11'h424, d); chk(d == 32'h100, "R9 mask reset", d, 32'h100);
  endtask

  task automatic t_buffer();
    logic [31:0] d;
    load_cmd(BUF, 3);
    for (int i = 0; i < BUF; i++) begin
      bus_rd(11'(i), d);
      chk(d == 32'(cmd_ref[i]), "R1 cmd readback", d, 32'(cmd_ref[i]));
    end
  endtask

  task automatic t_mode0();
    logic [31:0] d;
    load_cmd(4, 5);
    run_frame(4, 2, 1'b0, 3, 1'b0);
    chk(cs_mid == 7'h77, "R6 select 3 low", 32'(cs_mid), 32'h77);
    chk(rcnt == 32, "R3 edge count", 32'(rcnt), 32);
    check_xfer(4, "mode0");
    chk(per == 8 && hi_t == 4, "R5 code 2 timing", 32'(per), 8);
    chk(spi_sck == 1'b0 && spi_cs_n == 7'h7f, "R4 mode0 idle", 32'({spi_sck, spi_cs_n}), 32'h7f);
    bus_rd(11'h400, d);
    chk(d == ctl_val(3, 4, 2, 0, 0), "R2 ctl readback", d, ctl_val(3, 4, 2, 0, 0));
    bus_wr(11'h200, 32'hff);
    bus_rd(11'h200, d);
    chk(d[7:0] == sl_rsp[0], "R1 response not writable", d, 32'(sl_rsp[0]));
    bus_wr(11'h420, 32'h100);
    bus_rd(11'h420, d);
    chk(d == 0, "R8 write-one clear", d, 0);
  endtask

  task automatic t_mode3();
    load_cmd(3, 9);
    bus_wr(11'h400, ctl_val(0, 3, 7, 0, 1));
    chk(spi_sck == 1'b1, "R4 mode3 idle high", 32'(spi_sck), 1);
    run_frame(3, 7, 1'b1, 0, 1'b0);
    chk(cs_mid == 7'h7e, "R6 select 0 low", 32'(cs_mid), 32'h7e);
    chk(rcnt == 24, "R4 mode3 edge count", 32'(rcnt), 24);
    check_xfer(3, "mode3");
    chk(per == 28 && hi_t == 12, "R5 code 7 timing", 32'(hi_t), 12);
    chk(spi_sck == 1'b1, "R4 mode3 idle after", 32'(spi_sck), 1);
    bus_wr(11'h420, 32'h100);
  endtask

  task automatic t_speed();
    int codes[3] = '{0, 3, 5};
    int pexp[3]  = '{8, 12, 20};
    int hexp[3]  = '{4, 4, 8};
    for (int k = 0; k < 3; k++) begin
      load_cmd(1, k + 11);
      run_frame(1, codes[k], 1'b0, 5, 1'b0);
      chk(per == pexp[k], "R5 period", 32'(per), 32'(pexp[k]));
      chk(hi_t == hexp[k], "R5 high time", 32'(hi_t), 32'(hexp[k]));
      check_xfer(1, "speed");
      bus_wr(11'h420, 32'h100);
    end
  endtask

  task automatic t_sel7();
    load_cmd(2, 21);
    run_frame(2, 2, 1'b0, 7, 1'b0);
    chk(cs_mid == 7'h7f, "R6 select 7 none", 32'(cs_mid), 32'h7f);
    chk(rcnt == 0, "R6 select 7 no device edges", 32'(rcnt), 0);
    bus_wr(11'h420, 32'h100);
  endtask

  task automatic t_force();
    load_cmd(1, 31);
    run_frame(1, 2, 1'b0, 2, 1'b1);
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 7'h7b, "R7 held after frame 1", 32'(spi_cs_n), 32'h7b);
    check_xfer(1, "force1");
    bus_wr(11'h420, 32'h100);
    load_cmd(1, 32);
    run_frame(1, 2, 1'b0, 2, 1'b1);
    chk(cs_mid == 7'h7b && spi_cs_n == 7'h7b, "R7 held across frames", 32'(spi_cs_n), 32'h7b);
    check_xfer(1, "force2");
    bus_wr(11'h400, ctl_val(2, 1, 2, 0, 0));
    chk(spi_cs_n == 7'h7f, "R7 released", 32'(spi_cs_n), 32'h7f);
    bus_wr(11'h420, 32'h100);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    run_frame(0, 2, 1'b0, 1, 1'b0);
    bus_rd(11'h420, d);
    chk(d == 32'h100, "R8 zero length event", d, 32'h100);
    chk(rcnt == 0 && cs_mid == 7'h7f, "R8 zero length no edges", 32'(rcnt), 0);
    bus_wr(11'h420, 32'h100);
  endtask

  task automatic t_busy();
    logic [31:0] d, cv;
    load_cmd(2, 41);
    cv = ctl_val(1, 2, 7, 0, 0);
    bus_wr(11'h400, cv);
    rcnt = 0; spi_miso = sl_rsp[0][7];
    bus_wr(11'h400, cv | 32'h1);
    repeat (10) @(negedge clk);
    bus_wr(11'h400, ctl_val(4, 1, 2, 0, 0) | 32'h1);
    wait_evt();
    bus_rd(11'h400, d);
    chk(d == cv, "R10 fields unchanged", d, cv);
    chk(rcnt == 16, "R10 no restart", 32'(rcnt), 16);
    check_xfer(2, "busy");
    bus_wr(11'h420, 32'h100);
  endtask

  task automatic t_clamp();
    load_cmd(BUF, 51);
    run_frame(12, 2, 1'b0, 6, 1'b0);
    chk(rcnt == BUF * 8, "R11 clamp edges", 32'(rcnt), 32'(BUF * 8));
    check_xfer(BUF, "clamp R11");
    bus_wr(11'h420, 32'h100);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    load_cmd(1, 61);
    run_frame(1, 2, 1'b0, 0, 1'b0);
    chk(irq == 1'b0, "R9 masked", 32'(irq), 0);
    bus_wr(11'h424, 32'h0);
    chk(irq == 1'b1, "R9 unmasked", 32'(irq), 1);
    bus_wr(11'h420, 32'h100);
    chk(irq == 1'b0, "R9 cleared", 32'(irq), 0);
    bus_rd(11'h420, d);
    chk(d == 0, "R8 event cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buffer();
    t_mode0();
    t_mode3();
    t_speed();
    t_sel7();
    t_force();
    t_zero();
    t_busy();
    t_clamp();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule